// File: doc/BRIEF.md
# Pipelined Posit Field Adder

This block adds or subtracts two posit operands that have already been unpacked into fields. Each operand arrives as a sign, a signed scale (the power of two applied to the mantissa), a fraction with the hidden bit left out, and two flags that mark infinity and zero. The result leaves the block in the same unpacked form. Its fraction keeps every bit the alignment step kept, so another adder or accumulator can consume the result directly, and rounding to a packed word is left to a later stage.

Work passes through four register stages. The first stage orders the operands by magnitude and measures their scale gap. The second aligns the smaller mantissa and adds or subtracts. The third finds the leading one and normalizes. The fourth resolves the special cases and drives the ports. A `start` strobe travels with each operand pair and comes out as `done`. A new pair may enter on every clock. A sticky `res_trunc` flag reports that alignment pushed set bits off the end of the smaller mantissa.

A result with scale `s` and fraction field `f` of width MANT_W has the value (-1)^sign x 2^s x (1 + f / 2^MANT_W), with MANT_W = FRAC_W + GUARD_W + 1.

Top module: `posit_field_adder`

## Requirements
- R1: A `start` sampled at rising edge e produces `done` high for exactly the one cycle that follows rising edge e+3. A new operand pair is accepted on every clock.
- R2: When `sub` is 1, the sign of b is inverted. If the effective signs are equal, the magnitudes are added. If they differ, the smaller magnitude is subtracted from the larger. The result sign is that of the larger-magnitude operand.
- R3: The smaller operand's mantissa (hidden bit 1, then its fraction, then GUARD_W zero bits) is shifted right by the scale difference. A difference of MANT_W or more leaves nothing of it.
- R4: `res_trunc` is 1 exactly when the alignment shift discards at least one set bit.
- R5: A finite nonzero result gives the exact sum of the aligned operands in the form above, with the leading one implied.
- R6: A carry out of the mantissa addition raises the result scale to one above the larger operand's scale, and no bit is lost.
- R7: An exact cancellation gives `res_zero`=1 with sign, scale, fraction and `res_trunc` all 0.
- R8: If either input is flagged infinite, the result has `res_inf`=1 and all other result fields and flags 0. Infinity takes priority over a zero flag on the other operand.
- R9: A zero operand passes the other operand through unchanged, with b's sign inverted when `sub`=1, and `res_trunc`=0. Two zero operands give `res_zero`=1.
- R10: While `rst_n` is low, `done` and every result port are 0, and an operation in flight when reset arrives is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operand pair valid this cycle |
| sub | input | 1 | 1 = compute a - b, 0 = a + b |
| a_sign | input | 1 | Sign of a |
| a_scale | input | SCALE_W | Signed scale of a |
| a_frac | input | FRAC_W | Fraction of a, no hidden bit |
| a_inf | input | 1 | a is infinite |
| a_zero | input | 1 | a is zero |
| b_sign | input | 1 | Sign of b |
| b_scale | input | SCALE_W | Signed scale of b |
| b_frac | input | FRAC_W | Fraction of b, no hidden bit |
| b_inf | input | 1 | b is infinite |
| b_zero | input | 1 | b is zero |
| done | output | 1 | Result valid |
| res_sign | output | 1 | Result sign |
| res_scale | output | SCALE_W+clog2(MANT_W+2)+1 | Signed result scale |
| res_frac | output | MANT_W | Unrounded result fraction, no hidden bit |
| res_inf | output | 1 | Result is infinite |
| res_zero | output | 1 | Result is zero |
| res_trunc | output | 1 | Alignment discarded set bits |

## Verification
Every result is due on the fourth rising edge, counting the edge that captures `start`, so the bench drives a pair on a falling edge and compares the fields four falling edges later. It then checks that `done` has dropped one cycle after that. For two pairs issued back to back, the results are checked on consecutive falling edges. The checker compares `done` with `start` delayed by four edges, and it compares the special flags with the inputs from the same four-edge window. Both checks are held off by a counter until four edges have passed since reset.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

   // Control bits that travel alongside the data through every stage.
   typedef struct packed {
      logic valid;
      logic inf;
   } pfa_ctl_t;

   // Aligned mantissa width: hidden bit + fraction + guard bits.
   function automatic int mant_width(int frac_w, int guard_w);
      return frac_w + guard_w + 1;
   endfunction

   // Result scale width: the input range grows by one for a carry and
   // shrinks by up to the sum width on cancellation.
   function automatic int res_scale_width(int scale_w, int mant_w);
      return scale_w + $clog2(mant_w + 2) + 1;
   endfunction

endpackage

// File: rtl/pfa_order.sv
// Stage 1: decide which operand has the larger magnitude and how far apart
// the two scales are, then register the ordered operands.
module pfa_order
   import pfa_pkg::*;
#(
   parameter int SCALE_W = 8,
   parameter int FRAC_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      sub,
   input  logic                      a_sign,
   input  logic signed [SCALE_W-1:0] a_scale,
   input  logic [FRAC_W-1:0]         a_frac,
   input  logic                      a_inf,
   input  logic                      a_zero,
   input  logic                      b_sign,
   input  logic signed [SCALE_W-1:0] b_scale,
   input  logic [FRAC_W-1:0]         b_frac,
   input  logic                      b_inf,
   input  logic                      b_zero,
   output pfa_ctl_t                  s1_ctl,
   output logic                      s1_sign,
   output logic                      s1_eff_sub,
   output logic signed [SCALE_W-1:0] s1_scale,
   output logic [FRAC_W:0]           s1_big_mant,
   output logic [FRAC_W:0]           s1_small_mant,
   output logic [SCALE_W:0]          s1_diff
);

   logic                      b_sign_eff;
   logic                      a_is_big;
   logic                      small_is_zero;
   logic [FRAC_W:0]           a_mant;
   logic [FRAC_W:0]           b_mant;
   logic signed [SCALE_W-1:0] big_scale;
   logic signed [SCALE_W-1:0] small_scale;
   logic signed [SCALE_W:0]   gap;

   always_comb begin
      b_sign_eff = b_sign ^ sub;
      a_mant     = a_zero ? '0 : {1'b1, a_frac};
      b_mant     = b_zero ? '0 : {1'b1, b_frac};

      // A zero operand always ranks as the smaller one.
      if (a_zero)
         a_is_big = 1'b0;
      else if (b_zero)
         a_is_big = 1'b1;
      else if (a_scale != b_scale)
         a_is_big = (a_scale > b_scale);
      else
         a_is_big = (a_frac >= b_frac);

      big_scale     = a_is_big ? a_scale : b_scale;
      small_scale   = a_is_big ? b_scale : a_scale;
      small_is_zero = a_is_big ? b_zero : a_zero;
      gap           = $signed({big_scale[SCALE_W-1], big_scale})
                    - $signed({small_scale[SCALE_W-1], small_scale});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_ctl        <= '0;
         s1_sign       <= 1'b0;
         s1_eff_sub    <= 1'b0;
         s1_scale      <= '0;
         s1_big_mant   <= '0;
         s1_small_mant <= '0;
         s1_diff       <= '0;
      end else begin
         s1_ctl.valid  <= start;
         s1_ctl.inf    <= a_inf | b_inf;
         s1_sign       <= a_is_big ? a_sign : b_sign_eff;
         s1_eff_sub    <= a_sign ^ b_sign_eff;
         s1_scale      <= big_scale;
         s1_big_mant   <= a_is_big ? a_mant : b_mant;
         s1_small_mant <= a_is_big ? b_mant : a_mant;
         s1_diff       <= (small_is_zero || gap[SCALE_W]) ? '0 : gap;
      end
   end

endmodule

// File: rtl/pfa_align_add.sv
// Stage 2: logarithmic right shifter with a sticky bit collected per level,
// followed by the unsigned mantissa add/subtract.
module pfa_align_add
   import pfa_pkg::*;
#(
   parameter int SCALE_W = 8,
   parameter int FRAC_W  = 8,
   parameter int GUARD_W = 4,
   localparam int MANT_W = mant_width(FRAC_W, GUARD_W)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  pfa_ctl_t                  s1_ctl,
   input  logic                      s1_sign,
   input  logic                      s1_eff_sub,
   input  logic signed [SCALE_W-1:0] s1_scale,
   input  logic [FRAC_W:0]           s1_big_mant,
   input  logic [FRAC_W:0]           s1_small_mant,
   input  logic [SCALE_W:0]          s1_diff,
   output pfa_ctl_t                  s2_ctl,
   output logic                      s2_sign,
   output logic signed [SCALE_W-1:0] s2_scale,
   output logic [MANT_W:0]           s2_sum,
   output logic                      s2_trunc
);

   localparam int AW = $clog2(MANT_W + 1);

   logic [AW-1:0]   amt;
   logic [MANT_W-1:0] lvl [AW+1];
   logic [AW:0]     lost;
   logic [MANT_W:0] big_ext;
   logic [MANT_W:0] small_ext;
   logic [MANT_W:0] sum;

   // Any gap of MANT_W or more clears the whole mantissa.
   assign amt     = (s1_diff >= (SCALE_W+1)'(MANT_W)) ? AW'(MANT_W) : s1_diff[AW-1:0];
   assign lvl[0]  = {s1_small_mant, {GUARD_W{1'b0}}};
   assign lost[0] = 1'b0;

   for (genvar k = 0; k < AW; k++) begin : g_shift
      localparam int SH = 1 << k;
      localparam logic [MANT_W-1:0] OUT_MASK =
         (SH >= MANT_W) ? {MANT_W{1'b1}} : ({MANT_W{1'b1}} >> (MANT_W - SH));
      always_comb begin
         lvl[k+1]  = amt[k] ? (lvl[k] >> SH) : lvl[k];
         lost[k+1] = lost[k] | (amt[k] & (|(lvl[k] & OUT_MASK)));
      end
   end

   always_comb begin
      big_ext   = {1'b0, s1_big_mant, {GUARD_W{1'b0}}};
      small_ext = {1'b0, lvl[AW]};
      sum       = s1_eff_sub ? (big_ext - small_ext) : (big_ext + small_ext);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_ctl   <= '0;
         s2_sign  <= 1'b0;
         s2_scale <= '0;
         s2_sum   <= '0;
         s2_trunc <= 1'b0;
      end else begin
         s2_ctl   <= s1_ctl;
         s2_sign  <= s1_sign;
         s2_scale <= s1_scale;
         s2_sum   <= sum;
         s2_trunc <= lost[AW];
      end
   end

endmodule

// File: rtl/pfa_normalize.sv
// Stage 3: leading-one detection and left normalization. The result keeps
// the carry position, so no bit of the sum is dropped.
module pfa_normalize
   import pfa_pkg::*;
#(
   parameter int SCALE_W = 8,
   parameter int MANT_W  = 13,
   parameter int OSC_W   = 13
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  pfa_ctl_t                  s2_ctl,
   input  logic                      s2_sign,
   input  logic signed [SCALE_W-1:0] s2_scale,
   input  logic [MANT_W:0]           s2_sum,
   input  logic                      s2_trunc,
   output pfa_ctl_t                  s3_ctl,
   output logic                      s3_sign,
   output logic [OSC_W-1:0]          s3_scale,
   output logic [MANT_W-1:0]         s3_frac,
   output logic                      s3_zero,
   output logic                      s3_trunc
);

   localparam int LZW = $clog2(MANT_W + 2);

   function automatic logic [LZW-1:0] lead_zeros(logic [MANT_W:0] v);
      logic [LZW-1:0] cnt;
      logic           seen;
      cnt  = '0;
      seen = 1'b0;
      for (int i = MANT_W; i >= 0; i--) begin
         if (!seen) begin
            if (v[i]) seen = 1'b1;
            else      cnt  = cnt + 1'b1;
         end
      end
      return cnt;
   endfunction

   logic [LZW-1:0]   lz;
   logic [MANT_W:0]  norm;
   logic [OSC_W-1:0] scale_n;
   logic             is_zero;

   always_comb begin
      lz      = lead_zeros(s2_sum);
      norm    = s2_sum << lz;
      is_zero = ~norm[MANT_W];
      scale_n = {{(OSC_W-SCALE_W){s2_scale[SCALE_W-1]}}, s2_scale}
              + OSC_W'(1) - OSC_W'(lz);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s3_ctl   <= '0;
         s3_sign  <= 1'b0;
         s3_scale <= '0;
         s3_frac  <= '0;
         s3_zero  <= 1'b0;
         s3_trunc <= 1'b0;
      end else begin
         s3_ctl   <= s2_ctl;
         s3_zero  <= is_zero;
         s3_trunc <= s2_trunc & ~is_zero;
         s3_sign  <= is_zero ? 1'b0 : s2_sign;
         s3_scale <= is_zero ? '0 : scale_n;
         s3_frac  <= is_zero ? '0 : norm[MANT_W-1:0];
      end
   end

endmodule

// File: rtl/posit_field_adder.sv
// Four-stage adder on unpacked posit fields with an unrounded result.
module posit_field_adder
   import pfa_pkg::*;
#(
   parameter int SCALE_W  = 8,
   parameter int FRAC_W   = 8,
   parameter int GUARD_W  = 4,
   localparam int MANT_W  = mant_width(FRAC_W, GUARD_W),
   localparam int OSC_W   = res_scale_width(SCALE_W, MANT_W)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      sub,
   input  logic                      a_sign,
   input  logic signed [SCALE_W-1:0] a_scale,
   input  logic [FRAC_W-1:0]         a_frac,
   input  logic                      a_inf,
   input  logic                      a_zero,
   input  logic                      b_sign,
   input  logic signed [SCALE_W-1:0] b_scale,
   input  logic [FRAC_W-1:0]         b_frac,
   input  logic                      b_inf,
   input  logic                      b_zero,
   output logic                      done,
   output logic                      res_sign,
   output logic [OSC_W-1:0]          res_scale,
   output logic [MANT_W-1:0]         res_frac,
   output logic                      res_inf,
   output logic                      res_zero,
   output logic                      res_trunc
);

   if (SCALE_W < 2) begin : g_bad_scale
      $error("posit_field_adder: SCALE_W must be at least 2");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("posit_field_adder: FRAC_W must be at least 1");
   end
   if (GUARD_W < 0) begin : g_bad_guard
      $error("posit_field_adder: GUARD_W must not be negative");
   end
   if (MANT_W >= (1 << SCALE_W)) begin : g_bad_span
      $error("posit_field_adder: scale difference cannot express the mantissa width");
   end

   pfa_ctl_t                  s1_ctl, s2_ctl, s3_ctl;
   logic                      s1_sign, s1_eff_sub;
   logic signed [SCALE_W-1:0] s1_scale;
   logic [FRAC_W:0]           s1_big_mant, s1_small_mant;
   logic [SCALE_W:0]          s1_diff;
   logic                      s2_sign, s2_trunc;
   logic signed [SCALE_W-1:0] s2_scale;
   logic [MANT_W:0]           s2_sum;
   logic                      s3_sign, s3_zero, s3_trunc;
   logic [OSC_W-1:0]          s3_scale;
   logic [MANT_W-1:0]         s3_frac;

   pfa_order #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W)) u_order (
      .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
      .a_sign(a_sign), .a_scale(a_scale), .a_frac(a_frac), .a_inf(a_inf), .a_zero(a_zero),
      .b_sign(b_sign), .b_scale(b_scale), .b_frac(b_frac), .b_inf(b_inf), .b_zero(b_zero),
      .s1_ctl(s1_ctl), .s1_sign(s1_sign), .s1_eff_sub(s1_eff_sub), .s1_scale(s1_scale),
      .s1_big_mant(s1_big_mant), .s1_small_mant(s1_small_mant), .s1_diff(s1_diff)
   );

   pfa_align_add #(.SCALE_W(SCALE_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) u_align (
      .clk(clk), .rst_n(rst_n),
      .s1_ctl(s1_ctl), .s1_sign(s1_sign), .s1_eff_sub(s1_eff_sub), .s1_scale(s1_scale),
      .s1_big_mant(s1_big_mant), .s1_small_mant(s1_small_mant), .s1_diff(s1_diff),
      .s2_ctl(s2_ctl), .s2_sign(s2_sign), .s2_scale(s2_scale), .s2_sum(s2_sum),
      .s2_trunc(s2_trunc)
   );

   pfa_normalize #(.SCALE_W(SCALE_W), .MANT_W(MANT_W), .OSC_W(OSC_W)) u_norm (
      .clk(clk), .rst_n(rst_n),
      .s2_ctl(s2_ctl), .s2_sign(s2_sign), .s2_scale(s2_scale), .s2_sum(s2_sum),
      .s2_trunc(s2_trunc),
      .s3_ctl(s3_ctl), .s3_sign(s3_sign), .s3_scale(s3_scale), .s3_frac(s3_frac),
      .s3_zero(s3_zero), .s3_trunc(s3_trunc)
   );

   // Stage 4: an infinite operand overrides whatever the datapath produced.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         res_sign  <= 1'b0;
         res_scale <= '0;
         res_frac  <= '0;
         res_inf   <= 1'b0;
         res_zero  <= 1'b0;
         res_trunc <= 1'b0;
      end else begin
         done      <= s3_ctl.valid;
         res_inf   <= s3_ctl.inf;
         res_zero  <= s3_ctl.inf ? 1'b0 : s3_zero;
         res_trunc <= s3_ctl.inf ? 1'b0 : s3_trunc;
         res_sign  <= s3_ctl.inf ? 1'b0 : s3_sign;
         res_scale <= s3_ctl.inf ? '0   : s3_scale;
         res_frac  <= s3_ctl.inf ? '0   : s3_frac;
      end
   end

endmodule

// File: rtl/pfa_checker.sv
module pfa_checker #(
   parameter int SCALE_W = 8,
   parameter int MANT_W  = 13,
   parameter int OSC_W   = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              a_inf,
   input logic              a_zero,
   input logic              b_inf,
   input logic              b_zero,
   input logic              done,
   input logic              res_sign,
   input logic [OSC_W-1:0]  res_scale,
   input logic [MANT_W-1:0] res_frac,
   input logic              res_inf,
   input logic              res_zero,
   input logic              res_trunc
);

   // Counts edges since reset so no $past reaches back before it.
   logic [2:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
   end

   a_r1_done_tracks_start: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd4) |-> (done == $past(start, 4)));

   a_r8_inf_from_inputs: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd4 && done) |-> (res_inf == $past(a_inf | b_inf, 4)));

   a_r8_inf_clean: assert property (@(posedge clk) disable iff (!rst_n)
      res_inf |-> (!res_zero && !res_trunc && !res_sign && res_frac == '0 && res_scale == '0));

   a_r7_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
      res_zero |-> (!res_sign && !res_trunc && res_frac == '0 && res_scale == '0));

   a_r9_both_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd4 && done && $past(a_zero && b_zero && !a_inf && !b_inf, 4)) |-> res_zero);

   a_r9_zero_no_trunc: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd4 && done && $past(a_zero || b_zero, 4)) |-> !res_trunc);

endmodule

bind posit_field_adder pfa_checker #(
   .SCALE_W(SCALE_W), .MANT_W(MANT_W), .OSC_W(OSC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start),
   .a_inf(a_inf), .a_zero(a_zero), .b_inf(b_inf), .b_zero(b_zero),
   .done(done), .res_sign(res_sign), .res_scale(res_scale), .res_frac(res_frac),
   .res_inf(res_inf), .res_zero(res_zero), .res_trunc(res_trunc)
);

// File: tb/sim_posit_field_adder.sv
module sim_posit_field_adder;

   localparam int CLK_PERIOD = 10;
   localparam int SW = 8;
   localparam int FW = 8;
   localparam int GW = 4;
   localparam int MW = FW + GW + 1;            // 13
   localparam int OW = SW + $clog2(MW + 2) + 1; // 13

   logic clk = 1'b0;
   logic rst_n, start, sub;
   logic a_sign, a_inf, a_zero, b_sign, b_inf, b_zero;
   logic signed [SW-1:0] a_scale, b_scale;
   logic [FW-1:0] a_frac, b_frac;
   logic done, res_sign, res_inf, res_zero, res_trunc;
   logic [OW-1:0] res_scale;
   logic [MW-1:0] res_frac;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   posit_field_adder #(.SCALE_W(SW), .FRAC_W(FW), .GUARD_W(GW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .sub(sub),
      .a_sign(a_sign), .a_scale(a_scale), .a_frac(a_frac), .a_inf(a_inf), .a_zero(a_zero),
      .b_sign(b_sign), .b_scale(b_scale), .b_frac(b_frac), .b_inf(b_inf), .b_zero(b_zero),
      .done(done), .res_sign(res_sign), .res_scale(res_scale), .res_frac(res_frac),
      .res_inf(res_inf), .res_zero(res_zero), .res_trunc(res_trunc)
   );

   typedef struct packed {
      logic [3:0]           req;
      logic                 sub;
      logic                 as;
      logic signed [SW-1:0] asc;
      logic [FW-1:0]        af;
      logic                 ai;
      logic                 az;
      logic                 bs;
      logic signed [SW-1:0] bsc;
      logic [FW-1:0]        bf;
      logic                 bi;
      logic                 bz;
      logic                 es;
      logic signed [OW-1:0] esc;
      logic [MW-1:0]        ef;
      logic                 ei;
      logic                 ez;
      logic                 et;
   } vec_t;

   localparam int NV = 14;
   // Value of a result: 2^scale * (1 + frac/2^13).
   localparam vec_t VECS [NV] = '{
      // R6 carry: 1.0 + 1.0 = 2.0
      '{4'd6, 1'b0, 1'b0, 8'sd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'sd0, 8'h00, 1'b0, 1'b0,
        1'b0, 13'sd1, 13'h0000, 1'b0, 1'b0, 1'b0},
      // R3 shift by one: 1.5 + 0.5 = 2.0
      '{4'd3, 1'b0, 1'b0, 8'sd0, 8'h80, 1'b0, 1'b0, 1'b0, -8'sd1, 8'h00, 1'b0, 1'b0,
        1'b0, 13'sd1, 13'h0000, 1'b0, 1'b0, 1'b0},
      // R7 exact cancellation: 1.25*4 - 1.25*4
      '{4'd7, 1'b1, 1'b0, 8'sd2, 8'h40, 1'b0, 1'b0, 1'b0, 8'sd2, 8'h40, 1'b0, 1'b0,
        1'b0, 13'sd0, 13'h0000, 1'b0, 1'b1, 1'b0},
      // R2 unlike signs: 12 + (-8) = 4
      '{4'd2, 1'b0, 1'b0, 8'sd3, 8'h80, 1'b0, 1'b0, 1'b1, 8'sd3, 8'h00, 1'b0, 1'b0,
        1'b0, 13'sd2, 13'h0000, 1'b0, 1'b0, 1'b0},
      // R2 sub flips b, b larger: 1.0 - 1.5 = -0.5
      '{4'd2, 1'b1, 1'b0, 8'sd0, 8'h00, 1'b0, 1'b0, 1'b0, 8'sd0, 8'h80, 1'b0, 1'b0,
        1'b1, -13'sd1, 13'h0000, 1'b0, 1'b0, 1'b0},
      // R4 set bit lost: 1024 + 1.00390625
      '{4'd4, 1'b0, 1'b0, 8'sd10, 8'h00, 1'b0, 1'b0, 1'b0, 8'sd0, 8'h01, 1'b0, 1'b0,
        1'b0, 13'sd10, 13'h0008, 1'b0, 1'b0, 1'b1},
      // R3 within guard bits, nothing lost: 4 + 1 = 5
      '{4'd3, 1'b0, 1'b0, 8'sd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'sd0, 8'h00, 1'b0, 1'b0,
        1'b0, 13'sd2, 13'h0800, 1'b0, 1'b0, 1'b0},
      // R4 gap beyond mantissa width clears the smaller operand
      '{4'd4, 1'b0, 1'b1, 8'sd20, 8'h00, 1'b0, 1'b0, 1'b0, 8'sd0, 8'hFF, 1'b0, 1'b0,
        1'b1, 13'sd20, 13'h0000, 1'b0, 1'b0, 1'b1},
      // R8 a infinite
      '{4'd8, 1'b0, 1'b1, 8'sd5, 8'h33, 1'b1, 1'b0, 1'b0, 8'sd0, 8'h00, 1'b0, 1'b0,
        1'b0, 13'sd0, 13'h0000, 1'b1, 1'b0, 1'b0},
      // R9 a zero, sub: 0 - 1.5*32
      '{4'd9, 1'b1, 1'b0, 8'sd0, 8'h00, 1'b0, 1'b1, 1'b0, 8'sd5, 8'h80, 1'b0, 1'b0,
        1'b1, 13'sd5, 13'h1000, 1'b0, 1'b0, 1'b0},
      // R9 both zero
      '{4'd9, 1'b0, 1'b0, 8'sd3, 8'h00, 1'b0, 1'b1, 1'b1, 8'sd7, 8'h00, 1'b0, 1'b1,
        1'b0, 13'sd0, 13'h0000, 1'b0, 1'b1, 1'b0},
      // R6 carry with fraction, negative scale: 1.75/8 + 1.75/8
      '{4'd6, 1'b0, 1'b0, -8'sd3, 8'hC0, 1'b0, 1'b0, 1'b0, -8'sd3, 8'hC0, 1'b0, 1'b0,
        1'b0, -13'sd2, 13'h1800, 1'b0, 1'b0, 1'b0},
      // R8 infinity wins over a zero operand
      '{4'd8, 1'b0, 1'b0, 8'sd0, 8'h00, 1'b0, 1'b1, 1'b1, 8'sd1, 8'h10, 1'b1, 1'b0,
        1'b0, 13'sd0, 13'h0000, 1'b1, 1'b0, 1'b0},
      // R5 general sum: 1.0 + 0.375 = 1.375
      '{4'd5, 1'b0, 1'b0, 8'sd0, 8'h00, 1'b0, 1'b0, 1'b0, -8'sd2, 8'h80, 1'b0, 1'b0,
        1'b0, 13'sd0, 13'h0C00, 1'b0, 1'b0, 1'b0}
   };

   task automatic drive(vec_t v, logic st);
      start = st;  sub = v.sub;
      a_sign = v.as; a_scale = v.asc; a_frac = v.af; a_inf = v.ai; a_zero = v.az;
      b_sign = v.bs; b_scale = v.bsc; b_frac = v.bf; b_inf = v.bi; b_zero = v.bz;
   endtask

   task automatic expect_all(string tag, logic e_done, logic es, logic [OW-1:0] esc,
                             logic [MW-1:0] ef, logic ei, logic ez, logic et);
      n_tests++;
      if ({done, res_sign, res_scale, res_frac, res_inf, res_zero, res_trunc} !==
          {e_done, es, esc, ef, ei, ez, et}) begin
         n_fail++;
         $display("FAIL %s: actual done=%b s=%b sc=%0d f=%h inf=%b zero=%b tr=%b expected done=%b s=%b sc=%0d f=%h inf=%b zero=%b tr=%b",
                  tag, done, res_sign, $signed(res_scale), res_frac, res_inf, res_zero, res_trunc,
                  e_done, es, $signed(esc), ef, ei, ez, et);
      end
   endtask

   task automatic expect_vec(string tag, vec_t v);
      expect_all(tag, 1'b1, v.es, v.esc, v.ef, v.ei, v.ez, v.et);
   endtask

   task automatic expect_done(string tag, logic e_done);
      n_tests++;
      if (done !== e_done) begin
         n_fail++;
         $display("FAIL %s: actual done=%b expected done=%b", tag, done, e_done);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (4000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R1: actual=no completion expected=completion");
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0;
      drive('0, 1'b0);
      repeat (3) @(negedge clk);
      // R10: outputs idle under reset
      expect_all("R10 reset state", 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: drive one pair, sample on the fourth falling edge.
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i], 1'b1);
         @(negedge clk);
         start = 1'b0;
         repeat (3) @(negedge clk);
         expect_vec($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i]);
      end

      // R1: done is a single-cycle pulse
      @(negedge clk);
      expect_done("R1 done drops after one cycle", 1'b0);

      // R1: back-to-back pairs come out on consecutive cycles
      drive(VECS[0], 1'b1);
      @(negedge clk);
      drive(VECS[13], 1'b1);
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      expect_vec("R1 back-to-back first", VECS[0]);
      @(negedge clk);
      expect_vec("R1 back-to-back second", VECS[13]);
      @(negedge clk);
      expect_done("R1 back-to-back ends", 1'b0);

      // R10: a pair in flight is discarded by reset
      drive(VECS[5], 1'b1);
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         expect_all("R10 flush in flight", 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
      end
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      expect_done("R10 no late done after reset", 1'b0);

      finished = 1'b1;
      finish_run();
   end

endmodule